// File: doc/BRIEF.md
# Accelerometer Bring-Up and Polling Sequencer

This block drives a byte-oriented register access master that talks to a three-axis accelerometer over a serial link. After reset it reads the device identity byte and compares it with the expected value. When the identity matches, it writes one configuration byte that places the sensor in active measurement mode. When it does not match, it stops and raises an error flag.

Once the sensor is active, the block runs a polling loop. It waits a programmable number of idle cycles, then reads a status byte to see whether a new set of samples is ready. When a set is ready, it fetches the six output bytes in one burst read. Each axis arrives as a left-justified 14-bit two's-complement value split over two bytes, most significant byte first. The block forms a signed 16-bit word from the two bytes and shifts it right arithmetically by two. The three 14-bit results appear together with a one-cycle strobe.

The request side is a hold-until-accepted handshake. Each request carries a direction, an 8-bit register address, one write byte and a byte count. The master returns read bytes one per `rd_valid` cycle. It pulses `xfer_done` in a later cycle than the last byte, once the transaction has ended.

Top module: `accel_poll_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sample_valid`, `id_error` and all three axis outputs are 0.
- R2: The first request after reset is a one-byte read (`req_write`=0, `req_len`=1) of address 0x0D.
- R3: If the identity byte returned is 0x6A, the next request is a one-byte write (`req_write`=1) of data 0x3D to address 0x2A. This is the only write the block ever issues.
- R4: If the identity byte is any other value, `id_error` goes to 1 in the cycle after `xfer_done` and stays at 1 until reset. No further request is raised, so the configuration write is never issued.
- R5: After the configuration write completes, and after every status or data read completes, `req_valid` stays low for exactly `poll_gap`+1 cycles. The next request is then a one-byte read of status address 0x00.
- R6: A status byte with bit 3 clear causes another idle gap and another status read, whatever its other bits are. A status byte with bit 3 set causes a six-byte read (`req_len`=6) starting at address 0x01.
- R7: In the six returned bytes, bytes 0/1 are X MSB/LSB, bytes 2/3 are Y, and bytes 4/5 are Z. Each axis output equals the low 14 bits of the signed 16-bit word {MSB,LSB} shifted right arithmetically by 2.
- R8: `sample_valid` is high for exactly one cycle: the cycle after the data read's `xfer_done`. The axis outputs change only in that cycle and otherwise hold their value.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_write`, `req_addr`, `req_wdata` and `req_len` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_gap | input | GAP_W | Number of idle cycles between polls, minus one |
| req_valid | output | 1 | Register access request pending |
| req_ready | input | 1 | Master accepts the request this cycle |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 8 | Register address |
| req_wdata | output | 8 | Byte to write |
| req_len | output | 3 | Number of bytes to transfer |
| rd_valid | input | 1 | A read byte is present on rd_data |
| rd_data | input | 8 | Read byte, in address order |
| xfer_done | input | 1 | Current transaction finished |
| accel_x | output | 14 | Signed X sample |
| accel_y | output | 14 | Signed Y sample |
| accel_z | output | 14 | Signed Z sample |
| sample_valid | output | 1 | One-cycle strobe for a new X/Y/Z set |
| id_error | output | 1 | Identity mismatch, sticky until reset |

## Verification
The unpacking is driven with byte sets chosen to expose each kind of fault. A positive value shows whether the shift is applied. The most negative value shows whether the sign is extended. A word with both low bits set shows whether those discarded bits leak into the result. Distinct bytes per axis show whether axes are swapped or bytes reversed. Status bytes with only bit 3 set and with every bit except bit 3 set separate a correct bit select from a nonzero test. Idle gaps measured at two `poll_gap` settings and a request stalled against `req_ready` check the cycle accounting and the hold rule. Both a good and a bad identity byte are used to exercise the two exits from bring-up.

// File: rtl/accel_seq_pkg.sv
package accel_seq_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int JUSTIFY  = 2;
    localparam int SAMPLE_W = WORD_W - JUSTIFY;
    localparam int NUM_AXES = 3;
    localparam int BURST    = 2 * NUM_AXES;
    localparam int IDX_W    = $clog2(BURST + 1);
    localparam int LEN_W    = 3;

    typedef enum logic [3:0] {
        S_ID_REQ,
        S_ID_WAIT,
        S_CFG_REQ,
        S_CFG_WAIT,
        S_GAP,
        S_ST_REQ,
        S_ST_WAIT,
        S_DAT_REQ,
        S_DAT_WAIT,
        S_HALT
    } seq_state_e;

    typedef struct packed {
        seq_state_e                             state;
        logic [IDX_W-1:0]                       idx;
        logic [BURST-1:0][BYTE_W-1:0]           bytes;
        logic [NUM_AXES-1:0][SAMPLE_W-1:0]      smp;
        logic                                   valid;
        logic                                   err;
    } seq_regs_t;

endpackage

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [GAP_W-1:0] limit,
    output logic             expired
);

    logic [GAP_W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q >= limit);

    always_comb begin
        cnt_d = cnt_q;
        if (arm) begin
            cnt_d = '0;
        end else if (!expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (cnt_q == '0));

endmodule

// File: rtl/seq_axis_pack.sv
module seq_axis_pack
    import accel_seq_pkg::*;
(
    input  logic [BURST-1:0][BYTE_W-1:0]      raw,
    output logic [NUM_AXES-1:0][SAMPLE_W-1:0] val
);

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        logic signed [WORD_W-1:0] word;
        logic signed [WORD_W-1:0] shifted;
        assign word    = {raw[2*a], raw[2*a+1]};
        assign shifted = word >>> JUSTIFY;
        assign val[a]  = shifted[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/accel_poll_seq.sv
module accel_poll_seq
    import accel_seq_pkg::*;
#(
    parameter int          GAP_W     = 16,
    parameter logic [7:0]  ID_ADDR   = 8'h0D,
    parameter logic [7:0]  ID_VAL    = 8'h6A,
    parameter logic [7:0]  CFG_ADDR  = 8'h2A,
    parameter logic [7:0]  CFG_VAL   = 8'h3D,
    parameter logic [7:0]  STAT_ADDR = 8'h00,
    parameter int          READY_BIT = 3,
    parameter logic [7:0]  DATA_ADDR = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GAP_W-1:0]     poll_gap,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic                 req_write,
    output logic [7:0]           req_addr,
    output logic [7:0]           req_wdata,
    output logic [LEN_W-1:0]     req_len,
    input  logic                 rd_valid,
    input  logic [7:0]           rd_data,
    input  logic                 xfer_done,
    output logic [SAMPLE_W-1:0]  accel_x,
    output logic [SAMPLE_W-1:0]  accel_y,
    output logic [SAMPLE_W-1:0]  accel_z,
    output logic                 sample_valid,
    output logic                 id_error
);

    seq_regs_t r_d, r_q;
    logic      gap_arm, gap_expired;
    logic [NUM_AXES-1:0][SAMPLE_W-1:0] unpacked;

    seq_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (gap_arm),
        .limit   (poll_gap),
        .expired (gap_expired)
    );

    seq_axis_pack u_pack (
        .raw (r_q.bytes),
        .val (unpacked)
    );

    // Request fields decoded from the registered state
    always_comb begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        req_len   = LEN_W'(1);
        unique case (r_q.state)
            S_ID_REQ:  begin req_valid = 1'b1; req_addr = ID_ADDR; end
            S_CFG_REQ: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_addr  = CFG_ADDR;
                req_wdata = CFG_VAL;
            end
            S_ST_REQ:  begin req_valid = 1'b1; req_addr = STAT_ADDR; end
            S_DAT_REQ: begin
                req_valid = 1'b1;
                req_addr  = DATA_ADDR;
                req_len   = LEN_W'(BURST);
            end
            default: ;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;

        // Byte capture for any read in flight
        if ((r_q.state inside {S_ID_WAIT, S_ST_WAIT, S_DAT_WAIT}) &&
            rd_valid && (r_q.idx < IDX_W'(BURST))) begin
            r_d.bytes[r_q.idx] = rd_data;
            r_d.idx            = r_q.idx + 1'b1;
        end

        unique case (r_q.state)
            S_ID_REQ:   if (req_ready) begin r_d.state = S_ID_WAIT;  r_d.idx = '0; end
            S_ID_WAIT:  if (xfer_done) begin
                if (r_q.bytes[0] == ID_VAL) begin
                    r_d.state = S_CFG_REQ;
                end else begin
                    r_d.state = S_HALT;
                    r_d.err   = 1'b1;
                end
            end
            S_CFG_REQ:  if (req_ready) r_d.state = S_CFG_WAIT;
            S_CFG_WAIT: if (xfer_done) r_d.state = S_GAP;
            S_GAP:      if (gap_expired) r_d.state = S_ST_REQ;
            S_ST_REQ:   if (req_ready) begin r_d.state = S_ST_WAIT;  r_d.idx = '0; end
            S_ST_WAIT:  if (xfer_done) begin
                r_d.state = r_q.bytes[0][READY_BIT] ? S_DAT_REQ : S_GAP;
            end
            S_DAT_REQ:  if (req_ready) begin r_d.state = S_DAT_WAIT; r_d.idx = '0; end
            S_DAT_WAIT: if (xfer_done) begin
                r_d.state = S_GAP;
                r_d.smp   = unpacked;
                r_d.valid = 1'b1;
            end
            default:    r_d.state = S_HALT;
        endcase
    end

    assign gap_arm = (r_d.state == S_GAP) && (r_q.state != S_GAP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_ID_REQ;
        end else begin
            r_q <= r_d;
        end
    end

    assign accel_x      = r_q.smp[0];
    assign accel_y      = r_q.smp[1];
    assign accel_z      = r_q.smp[2];
    assign sample_valid = r_q.valid;
    assign id_error     = r_q.err;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_write) &&
            $stable(req_addr) && $stable(req_wdata) && $stable(req_len)));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R8
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> ($stable(accel_x) && $stable(accel_y) && $stable(accel_z)));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_error |=> id_error);

    // R4
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_error |-> !req_valid);

    // R3
    only_cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> (req_addr == CFG_ADDR && req_wdata == CFG_VAL && !id_error));

endmodule

// File: tb/accel_poll_seq_bench.sv
`timescale 1ns/1ps
module accel_poll_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] poll_gap = 16'd3;
    logic        req_valid, req_ready = 1'b0, req_write;
    logic [7:0]  req_addr, req_wdata;
    logic [2:0]  req_len;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        xfer_done = 1'b0;
    logic [13:0] accel_x, accel_y, accel_z;
    logic        sample_valid, id_error;

    int checks = 0;
    int errors = 0;
    int vcount;
    int cycles = 0;

    always #2 clk = ~clk;

    accel_poll_seq u_accel_poll_seq (
        .clk(clk), .rst_n(rst_n), .poll_gap(poll_gap),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
        .rd_valid(rd_valid), .rd_data(rd_data), .xfer_done(xfer_done),
        .accel_x(accel_x), .accel_y(accel_y), .accel_z(accel_z),
        .sample_valid(sample_valid), .id_error(id_error)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int exp_axis(input logic [7:0] m, input logic [7:0] l);
        logic signed [15:0] w;
        w = {m, l};
        return int'(w >>> 2);
    endfunction

    // Act as the register access master for one transaction
    task automatic serve(input string rq, input logic ew, input logic [7:0] ea,
                         input logic [7:0] ewd, input int elen,
                         input logic [47:0] rbytes, input int stall);
        int wait_n = 0;
        while (!req_valid && wait_n < 2000) begin
            wait_n++;
            @(negedge clk);
        end
        check(req_valid, rq, "request raised", req_valid, 1);
        check(req_write == ew, rq, "req_write", req_write, ew);
        check(req_addr == ea, rq, "req_addr", req_addr, ea);
        if (ew) check(req_wdata == ewd, rq, "req_wdata", req_wdata, ewd);
        check(int'(req_len) == elen, rq, "req_len", req_len, elen);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check(req_valid && req_write == ew && req_addr == ea && int'(req_len) == elen,
                  "R9", "fields held during stall", req_addr, ea);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        if (!ew) begin
            for (int i = 0; i < elen; i++) begin
                rd_valid = 1'b1;
                rd_data  = rbytes[47-8*i -: 8];
                @(negedge clk);
            end
            rd_valid = 1'b0;
        end
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic measure_gap(input string rq, input int exp);
        int cnt = 0;
        vcount = 0;
        while (!req_valid && cnt < 2000) begin
            if (sample_valid) vcount++;
            cnt++;
            @(negedge clk);
        end
        check(cnt == exp, rq, "idle cycles before poll", cnt, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!sample_valid && !id_error && accel_x == 0 && accel_y == 0 && accel_z == 0,
              "R1", "outputs in reset", {sample_valid, id_error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sample_valid && !id_error && accel_x == 0,
              "R1", "outputs after reset", {sample_valid, id_error}, 0);
    endtask

    task automatic t_bringup();
        serve("R2", 1'b0, 8'h0D, 8'h00, 1, {8'h6A, 40'h0}, 0);
        check(!id_error, "R3", "no error on good identity", id_error, 0);
        serve("R3", 1'b1, 8'h2A, 8'h3D, 1, 48'h0, 0);
        measure_gap("R5", int'(poll_gap) + 1);
    endtask

    task automatic t_not_ready(input logic [7:0] st);
        serve("R6", 1'b0, 8'h00, 8'h00, 1, {st, 40'h0}, 0);
        measure_gap("R6", int'(poll_gap) + 1);
        check(req_addr == 8'h00 && int'(req_len) == 1, "R6", "repoll status", req_addr, 0);
    endtask

    task automatic t_sample(input logic [47:0] b, input int stall);
        int ex, ey, ez;
        logic [13:0] hx;
        ex = exp_axis(b[47:40], b[39:32]);
        ey = exp_axis(b[31:24], b[23:16]);
        ez = exp_axis(b[15:8],  b[7:0]);
        serve("R6", 1'b0, 8'h00, 8'h00, 1, {8'h08, 40'h0}, 0);
        serve("R6", 1'b0, 8'h01, 8'h00, 6, b, stall);
        check(sample_valid, "R8", "strobe after data done", sample_valid, 1);
        check(int'($signed(accel_x)) == ex, "R7", "accel_x", $signed(accel_x), ex);
        check(int'($signed(accel_y)) == ey, "R7", "accel_y", $signed(accel_y), ey);
        check(int'($signed(accel_z)) == ez, "R7", "accel_z", $signed(accel_z), ez);
        hx = accel_x;
        measure_gap("R5", int'(poll_gap) + 1);
        check(vcount == 1, "R8", "strobe length", vcount, 1);
        check(accel_x == hx, "R8", "sample held", accel_x, hx);
    endtask

    task automatic t_bad_id();
        do_reset();
        serve("R4", 1'b0, 8'h0D, 8'h00, 1, {8'h6B, 40'h0}, 0);
        check(id_error, "R4", "error flag raised", id_error, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(!req_valid && id_error, "R4", "halted with no requests",
                  {req_valid, id_error}, 1);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_bringup();
        t_not_ready(8'hF7);
        t_sample({8'h12, 8'h34, 8'h56, 8'h78, 8'h0A, 8'hBC}, 0);
        poll_gap = 16'd0;
        measure_gap("R5", 0);
        t_not_ready(8'h00);
        t_sample({8'h80, 8'h00, 8'h7F, 8'hFF, 8'hFF, 8'hFC}, 3);
        poll_gap = 16'd7;
        t_sample({8'hC3, 8'h01, 8'h00, 8'h07, 8'hE5, 8'h5A}, 1);
        t_bad_id();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule